// File: doc/BRIEF.md
# Depth-Banked Low-Power Word Memory

This block is a synchronous single-port word memory. It is split along its depth into a number of equal banks. The upper address bits choose one bank and the lower bits choose a word inside it. On a read or a write, the enable goes only to the bank that holds the addressed word, so at most one bank's storage and read port switch in a cycle. When no access is requested, every bank stays idle. The cost is a selection stage on the read path. That stage uses the bank index of the last read, captured as a register, to pick one bank output for the data port.

Every bank keeps its read output unchanged while it is being written. A write therefore never disturbs the data port. The port keeps the word from the last read until another read replaces it. A read returns its data one clock after it is accepted, along with a one-cycle valid strobe. When read and write are asked for in the same cycle, the write is performed and no read is issued. The number of banks, the words per bank and the word width are parameters. A depth of 32K words in 1K-word banks is one intended setting, and the shipped defaults are smaller.

Top module: `bankmem_top`

## Requirements
- R1: The bank index is `addr[ADDR_W-1:OFS_W]` and the word offset is `addr[OFS_W-1:0]`, where OFS_W = log2(BANK_DEPTH). A word written at any address is returned unchanged by a later read of that same address.
- R2: When `rd_en` is high and `wr_en` is low at a rising edge, `rd_valid` is high for exactly the following cycle and `rd_data` shows the stored word during that cycle.
- R3: In any cycle with `rd_en` or `wr_en` high, `bank_en` has exactly one bit set, and that bit is the one at position addr / BANK_DEPTH.
- R4: In any cycle with both `rd_en` and `wr_en` low, `bank_en` is all zero.
- R5: When `rd_en` and `wr_en` are both high, the write is stored and `rd_valid` stays low in the next cycle.
- R6: A write, including one to the bank and offset of the last read, leaves `rd_data` unchanged.
- R7: While `rst_n` is low and after it is released, `rd_data` is zero and `rd_valid` is low until the first read.
- R8: In cycles that do not follow an accepted read, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request; takes priority over rd_en |
| addr | input | ADDR_W | Word address: bank index in the upper bits, offset in the lower bits |
| wr_data | input | DATA_W | Data to be written |
| rd_data | output | DATA_W | Data from the last read, held between reads |
| rd_valid | output | 1 | High in the cycle after an accepted read |
| bank_en | output | NUM_BANKS | Per-bank enable of the current cycle; one-hot or zero |

## Verification
The bench uses a four-bank, sixteen-word-per-bank configuration. It writes every address and reads all of them back in both directions. A wrong split between bank index and offset would alias words or send the enable to a neighbouring bank, and the per-cycle enable comparison and the readback would both catch that. Writes are aimed at the bank and offset that were just read, and writes are mixed with idle cycles. A bank that updated its output on a write, or a selector that followed the write's bank, would change `rd_data` when it should hold. Simultaneous read and write requests check that the write is kept and that no valid strobe is produced. A design that issued the read instead would assert `rd_valid` or lose the stored word.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } mem_op_e;

  // A write request always wins over a concurrent read request.
  function automatic mem_op_e resolve_op(input logic rd, input logic wr);
    if (wr)      return OP_WRITE;
    else if (rd) return OP_READ;
    else         return OP_IDLE;
  endfunction

endpackage

// File: rtl/bankmem_decode.sv
module bankmem_decode #(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_DEPTH = 128,
  localparam int OFS_W  = $clog2(BANK_DEPTH),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = OFS_W + BANK_W
) (
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic                 write_go,
  output logic                 read_go,
  output logic [BANK_W-1:0]    bank_idx,
  output logic [OFS_W-1:0]     offset
);
  import bankmem_pkg::*;

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  mem_op_e op;
  logic    access_req;

  always_comb begin
    op         = resolve_op(rd_en, wr_en);
    access_req = (op != OP_IDLE);
    write_go   = (op == OP_WRITE);
    read_go    = (op == OP_READ);
    bank_idx   = bank_of(addr);
    offset     = offset_of(addr);
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_en
    assign bank_en[g] = access_req && (bank_idx == BANK_W'(g));
  end

endmodule

// File: rtl/bankmem_bank.sv
module bankmem_bank #(
  parameter int BANK_DEPTH = 128,
  parameter int DATA_W     = 32,
  localparam int OFS_W = $clog2(BANK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] mem [BANK_DEPTH];

  // Storage: touched only when this bank is enabled for a write.
  always_ff @(posedge clk) begin
    if (en && we) mem[ofs] <= din;
  end

  // Read port in no-change style: updated on enabled reads only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dout <= '0;
    else if (en && !we)  dout <= mem[ofs];
  end

endmodule

// File: rtl/bankmem_rdmux.sv
module bankmem_rdmux #(
  parameter int NUM_BANKS = 8,
  parameter int DATA_W    = 32,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              read_go,
  input  logic [BANK_W-1:0]                 bank_idx,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_dout,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              rd_valid
);
  logic [BANK_W-1:0] sel_q;

  // The select register moves only on reads, so the port holds between reads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= read_go;
      if (read_go) sel_q <= bank_idx;
    end
  end

  assign rd_data = bank_dout[sel_q];

endmodule

// File: rtl/bankmem_top.sv
module bankmem_top #(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_DEPTH = 128,
  parameter int DATA_W     = 32,
  localparam int OFS_W  = $clog2(BANK_DEPTH),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = OFS_W + BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  output logic [NUM_BANKS-1:0] bank_en
);
  logic                             write_go;
  logic                             read_go;
  logic [BANK_W-1:0]                bank_idx;
  logic [OFS_W-1:0]                 offset;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_dout;

  bankmem_decode #(.NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH)) u_decode (
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .bank_en  (bank_en),
    .write_go (write_go),
    .read_go  (read_go),
    .bank_idx (bank_idx),
    .offset   (offset)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bankmem_bank #(.BANK_DEPTH(BANK_DEPTH), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (bank_en[g]),
      .we    (write_go),
      .ofs   (offset),
      .din   (wr_data),
      .dout  (bank_dout[g])
    );
  end

  bankmem_rdmux #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_rdmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .read_go   (read_go),
    .bank_idx  (bank_idx),
    .bank_dout (bank_dout),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/bankmem_chk.sv
module bankmem_chk #(
  parameter int NUM_BANKS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int OFS_W     = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_en,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [NUM_BANKS-1:0] bank_en,
  input logic                 rd_valid,
  input logic [DATA_W-1:0]    rd_data
);
  // R3
  onehot_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> $countones(bank_en) == 1);

  // R3
  addressed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> bank_en[addr[ADDR_W-1:OFS_W]]);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |-> bank_en == '0);

  // R2
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_valid);

  // R5
  no_valid_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_valid);

  // R8
  hold_between_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

  // R7
  always_comb begin
    if (!rst_n) reset_clear_chk: assert (rd_valid == 1'b0);
  end

endmodule

bind bankmem_top bankmem_chk #(
  .NUM_BANKS (NUM_BANKS),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .OFS_W     (OFS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .bank_en  (bank_en),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/bankmem_top_tb.sv
`timescale 1ns/1ps
module bankmem_top_tb;
  localparam int NB    = 4;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int WORDS = NB * DEPTH;
  localparam int AW    = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_en, wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [NB-1:0] bank_en;

  bankmem_top #(.NUM_BANKS(NB), .BANK_DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .bank_en(bank_en)
  );

  always #2.5 clk = ~clk;

  int            n_checks = 0;
  int            n_fail   = 0;
  bit            done     = 1'b0;
  logic [DW-1:0] model [WORDS];
  logic [DW-1:0] last_rd;

  function automatic logic [DW-1:0] pattern(input int a, input int salt);
    return DW'((a * 73 + salt * 911 + 17) ^ (a << 9));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, check the enable vector, then check the outputs
  // at the next falling edge.
  task automatic op(input bit rd, input bit wr, input int a, input logic [DW-1:0] d,
                    input string req);
    logic [NB-1:0] exp_en;
    bit            exp_valid;
    rd_en = rd; wr_en = wr; addr = AW'(a); wr_data = d;
    exp_en = (rd || wr) ? NB'(1 << (a / DEPTH)) : '0;
    #1;
    check(bank_en == exp_en, (rd || wr) ? "R3" : "R4", 32'(bank_en), 32'(exp_en));
    @(negedge clk);
    exp_valid = rd && !wr;
    if (wr) model[a] = d;
    check(rd_valid == exp_valid, wr && rd ? "R5" : "R2", 32'(rd_valid), 32'(exp_valid));
    if (exp_valid) begin
      check(rd_data == model[a], req, 32'(rd_data), 32'(model[a]));
      last_rd = model[a];
    end else begin
      check(rd_data == last_rd, wr ? "R6" : "R8", 32'(rd_data), 32'(last_rd));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    last_rd = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(rd_data == '0, "R7", 32'(rd_data), 0);
    check(rd_valid == 1'b0, "R7", 32'(rd_valid), 0);
    check(bank_en == '0, "R7", 32'(bank_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == '0 && rd_valid == 1'b0, "R7", 32'(rd_data), 0);

    // R1 fill every word, then read back in both directions
    for (int a = 0; a < WORDS; a++) op(1'b0, 1'b1, a, pattern(a, 1), "R1");
    for (int a = 0; a < WORDS; a++) op(1'b1, 1'b0, a, '0, "R1");
    for (int a = WORDS - 1; a >= 0; a--) op(1'b1, 1'b0, a, '0, "R2");

    // R8 idle cycles hold the last word
    for (int i = 0; i < 4; i++) op(1'b0, 1'b0, i * 7, '0, "R8");

    // R6 write the word just read, and other words of the same bank
    for (int b = 0; b < NB; b++) begin
      int a0 = b * DEPTH + (b * 5) % DEPTH;
      op(1'b1, 1'b0, a0, '0, "R2");
      op(1'b0, 1'b1, a0, pattern(a0, 2), "R6");
      op(1'b0, 1'b1, b * DEPTH + (a0 + 1) % DEPTH, pattern(a0 + 1, 3), "R6");
      op(1'b0, 1'b0, 0, '0, "R8");
      op(1'b1, 1'b0, a0, '0, "R6");
    end

    // R5 simultaneous requests: the write is kept, no read issued
    for (int a = 3; a < WORDS; a += 9) begin
      op(1'b1, 1'b1, a, pattern(a, 4), "R5");
      op(1'b1, 1'b0, a, '0, "R5");
    end

    // R1 bank-interleaved accesses at every offset
    for (int o = 0; o < DEPTH; o++)
      for (int b = 0; b < NB; b++) begin
        int a = ((b + o) % NB) * DEPTH + o;
        op(1'b0, 1'b1, a, pattern(a, 5), "R1");
        op(1'b1, 1'b0, (a + DEPTH) % WORDS, '0, "R1");
      end
    for (int a = 0; a < WORDS; a++) op(1'b1, 1'b0, a, '0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule